// File: doc/BRIEF.md
# Rotating-Priority Eight-Line Interrupt Controller

This block collects eight interrupt request lines, ranks them on a circular priority scale, and presents one interrupt with an eight-bit vector to a processor. Software drives it through a byte-wide register port. The port has a command address and a data address. A third strobe on the data address reaches the per-line trigger-select register.

Before it signals anything, software programs the block with a short startup sequence. After that it uses command writes for several purposes:
- to end service of a level, either the highest-ranked one or a named one;
- to move the priority pointer;
- to switch special mask mode on or off;
- to pick which register a command read returns;
- to arm a poll read.

A poll read lets software take the winning request without using the acknowledge pin. Each line can be edge- or level-triggered. With automatic end-of-interrupt, an acknowledge never leaves a level in service. It can also rotate priority to the level just taken.

Top module: `prio_intc`

## Requirements
- R1: A command write with bit 4 set starts initialization. It clears the request, in-service and mask registers, sets the priority pointer to 7 and clears the AEOI, rotate-on-AEOI, special-mask, poll and read-select flags. It also drops `intOut` from the next cycle.
- R2: After R1, data writes without `trigSel` load, in order, the vector base, a cascade word that is ignored, and a mode word whose bit 1 enables AEOI. All later data writes without `trigSel` load the mask. Data reads without `trigSel` return the mask.
- R3: A command write with bits 4:3 = 00 is an operation command, selected by bits 7:5. Code 1 clears the highest-priority in-service bit. Code 3 clears the in-service bit named by bits 2:0.
- R4: Operation code 6 loads the pointer from bits 2:0. Code 5 and code 7 act as code 1 and code 3 and also load the pointer with the cleared level. Code 4 enables rotate-on-AEOI and code 0 disables it.
- R5: Priority is circular: the level one above the pointer (mod 8) ranks highest.
- R6: A masked line never wins. In normal mode, an in-service bit of equal or higher rank suppresses the pending interrupt.
- R7: A command write with bit 7 = 0 and bits 4:3 = 01 is the read/mask command. When its bit 6 is 1, bit 5 sets (1) or clears (0) special mask mode. In special mask mode with a non-zero mask, in-service bits block nothing.
- R8: Lines whose trigger-select bit is 0 latch a request on a rising input edge. Lines whose bit is 1 follow the input level. Data writes and reads with `trigSel` = 1 access the trigger-select register.
- R9: On an accepted `intAck`, the winning request moves to in-service. With AEOI, it is not left in service, and with rotate-on-AEOI the pointer takes that level.
- R10: `intOut` is 0 until the mode word has been written. `intVec` is the vector base OR the 3-bit winning level.
- R11: In the read/mask command, bit 1 = 1 lets bit 0 choose what command reads return: the in-service register (1) or the request register (0).
- R12: The read/mask command with bit 2 set arms a poll. The next command read returns 0x80 OR the winning level and moves that request into service, or returns 0 if none is pending. The poll then disarms.
- R13: If a rising edge on an edge-triggered line coincides with the acknowledge of that same line, the request bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effects for poll) |
| addr | input | 1 | 0 = command address, 1 = data address |
| trigSel | input | 1 | With addr = 1, selects the trigger-select register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid while the address is held |
| irqReq | input | 8 | Interrupt request lines |
| intAck | input | 1 | Acknowledge of the presented interrupt |
| intOut | output | 1 | Interrupt pending |
| intVec | output | 8 | Vector of the pending interrupt |

## Verification
Two functions can land in the same cycle: the acknowledge clears a request bit, and the trigger logic can set that same bit on a new edge. The bench provokes this by raising the line again in the cycle of its acknowledge. It then reads the request register back and expects the bit still set. Rotation on acknowledge and circular ranking are judged together by checking that the vector moves to the next-ranked line right after an acknowledge under rotate-on-AEOI.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LINES  = 8;
  localparam int LVL_W  = $clog2(LINES);
  localparam int DATA_W = 8;

  typedef logic [LINES-1:0] lineVec_t;

  typedef struct packed {
    logic              initClr;
    logic              setBase;
    logic              setMask;
    logic              setTrig;
    logic              eoiNs;
    logic              eoiSp;
    logic              rotate;
    logic              setPrio;
    logic              take;
    logic [LVL_W-1:0]  lvl;
    logic [DATA_W-1:0] data;
  } dpStrobe_t;

  typedef struct packed {
    logic aeoi;
    logic rotAeoi;
    logic smm;
  } dpMode_t;

  // Returns {found, level}: first set bit scanning upward from ptr+1 (mod LINES).
  function automatic logic [LVL_W:0] pickFirst(input lineVec_t v, input logic [LVL_W-1:0] ptr);
    logic [LVL_W:0]   r;
    logic [LVL_W-1:0] idx;
    r = '0;
    for (int k = LINES; k >= 1; k--) begin
      idx = ptr + LVL_W'(k);
      if (v[idx]) r = {1'b1, idx};
    end
    return r;
  endfunction
endpackage

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            st,
  input  dpMode_t              mode,
  input  lineVec_t             reqIn,
  output lineVec_t             irrQ,
  output lineVec_t             isrQ,
  output lineVec_t             imrQ,
  output lineVec_t             trigQ,
  output logic [DATA_W-1:0]    baseQ,
  output logic                 pendValid,
  output logic [LVL_W-1:0]     pendLvl
);
  logic [LVL_W-1:0] prioQ, prioN;
  lineVec_t reqPrev, rise, blockSet, cand, irrN, isrN;
  logic [LVL_W:0] win, isrTop;

  always_comb begin
    isrTop    = pickFirst(isrQ, prioQ);
    blockSet  = (mode.smm && (|imrQ)) ? '0 : isrQ;
    cand      = (irrQ & ~imrQ) | blockSet;
    win       = pickFirst(cand, prioQ);
    pendLvl   = win[LVL_W-1:0];
    pendValid = win[LVL_W] && !blockSet[pendLvl];
  end

  always_comb begin
    rise = reqIn & ~reqPrev;
    irrN = irrQ;
    if (st.take) irrN[pendLvl] = 1'b0;
    if (st.initClr) irrN = '0;
    irrN = irrN | (rise & ~trigQ);
    irrN = (irrN & ~trigQ) | (reqIn & trigQ);

    isrN = isrQ;
    if (st.take && !mode.aeoi) isrN[pendLvl] = 1'b1;
    if (st.eoiSp) isrN[st.lvl] = 1'b0;
    if (st.eoiNs && isrTop[LVL_W]) isrN[isrTop[LVL_W-1:0]] = 1'b0;
    if (st.initClr) isrN = '0;

    prioN = prioQ;
    if (st.take && mode.aeoi && mode.rotAeoi) prioN = pendLvl;
    if (st.setPrio) prioN = st.lvl;
    if (st.rotate && st.eoiSp) prioN = st.lvl;
    if (st.rotate && st.eoiNs && isrTop[LVL_W]) prioN = isrTop[LVL_W-1:0];
    if (st.initClr) prioN = LVL_W'(LINES - 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPrev <= '0;
      irrQ    <= '0;
      isrQ    <= '0;
      imrQ    <= '0;
      trigQ   <= '0;
      baseQ   <= '0;
      prioQ   <= LVL_W'(LINES - 1);
    end else begin
      reqPrev <= reqIn;
      irrQ    <= irrN;
      isrQ    <= isrN;
      prioQ   <= prioN;
      if (st.initClr)      imrQ <= '0;
      else if (st.setMask) imrQ <= st.data[LINES-1:0];
      if (st.setTrig) trigQ <= st.data[LINES-1:0];
      if (st.setBase) baseQ <= st.data;
    end
  end
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              addr,
  input  logic              trigSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              intAck,
  input  logic              pendValid,
  input  logic [LVL_W-1:0]  pendLvl,
  input  lineVec_t          irrQ,
  input  lineVec_t          isrQ,
  input  lineVec_t          imrQ,
  input  lineVec_t          trigQ,
  output dpStrobe_t         st,
  output dpMode_t           mode,
  output logic              initDone,
  output logic [DATA_W-1:0] rdData
);
  typedef enum logic [2:0] {INIT_IDLE, INIT_BASE, INIT_CASC, INIT_MODE, INIT_DONE} initStep_e;
  initStep_e initQ;
  logic aeoiQ, rotAeoiQ, smmQ, pollQ, readIsrQ;
  logic cmdWr, dataWr, isIcw1, isOcw2, isOcw3, pollRd;
  logic [2:0] op;

  assign cmdWr    = wrEn && !addr;
  assign dataWr   = wrEn && addr;
  assign isIcw1   = cmdWr && wrData[4];
  assign isOcw2   = cmdWr && (wrData[4:3] == 2'b00);
  assign isOcw3   = cmdWr && !wrData[7] && (wrData[4:3] == 2'b01);
  assign op       = wrData[7:5];
  assign pollRd   = rdEn && !addr && !readIsrQ && pollQ;
  assign initDone = (initQ == INIT_DONE);
  assign mode     = '{aeoi: aeoiQ, rotAeoi: rotAeoiQ, smm: smmQ};

  always_comb begin
    st         = '0;
    st.data    = wrData;
    st.lvl     = wrData[LVL_W-1:0];
    st.initClr = isIcw1;
    if (dataWr && trigSel) st.setTrig = 1'b1;
    else if (dataWr) begin
      case (initQ)
        INIT_BASE:            st.setBase = 1'b1;
        INIT_IDLE, INIT_DONE: st.setMask = 1'b1;
        default:              ;
      endcase
    end
    if (isOcw2) begin
      case (op)
        3'd1: st.eoiNs = 1'b1;
        3'd3: st.eoiSp = 1'b1;
        3'd5: begin st.eoiNs = 1'b1; st.rotate = 1'b1; end
        3'd6: st.setPrio = 1'b1;
        3'd7: begin st.eoiSp = 1'b1; st.rotate = 1'b1; end
        default: ;
      endcase
    end
    st.take = pendValid && (pollRd || (intAck && initDone));
  end

  always_comb begin
    if (addr)          rdData = trigSel ? DATA_W'(trigQ) : DATA_W'(imrQ);
    else if (readIsrQ) rdData = DATA_W'(isrQ);
    else if (pollQ)    rdData = pendValid ? {1'b1, {(DATA_W-1-LVL_W){1'b0}}, pendLvl} : '0;
    else               rdData = DATA_W'(irrQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initQ    <= INIT_IDLE;
      aeoiQ    <= 1'b0;
      rotAeoiQ <= 1'b0;
      smmQ     <= 1'b0;
      pollQ    <= 1'b0;
      readIsrQ <= 1'b0;
    end else if (isIcw1) begin
      initQ    <= INIT_BASE;
      aeoiQ    <= 1'b0;
      rotAeoiQ <= 1'b0;
      smmQ     <= 1'b0;
      pollQ    <= 1'b0;
      readIsrQ <= 1'b0;
    end else begin
      if (dataWr && !trigSel) begin
        case (initQ)
          INIT_BASE: initQ <= INIT_CASC;
          INIT_CASC: initQ <= INIT_MODE;
          INIT_MODE: begin initQ <= INIT_DONE; aeoiQ <= wrData[1]; end
          default:   ;
        endcase
      end
      if (isOcw2 && op == 3'd0) rotAeoiQ <= 1'b0;
      if (isOcw2 && op == 3'd4) rotAeoiQ <= 1'b1;
      if (pollRd) pollQ <= 1'b0;
      if (isOcw3) begin
        if (wrData[6]) smmQ <= wrData[5];
        if (wrData[2]) pollQ <= 1'b1;
        if (wrData[1]) readIsrQ <= wrData[0];
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              addr,
  input  logic              trigSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [LINES-1:0]  irqReq,
  input  logic              intAck,
  output logic              intOut,
  output logic [DATA_W-1:0] intVec
);
  dpStrobe_t        st;
  dpMode_t          mode;
  lineVec_t         irrQ, isrQ, imrQ, trigQ;
  logic [DATA_W-1:0] baseQ;
  logic             pendValid, initDone;
  logic [LVL_W-1:0] pendLvl;

  irqc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .trigSel(trigSel), .wrData(wrData), .intAck(intAck),
    .pendValid(pendValid), .pendLvl(pendLvl),
    .irrQ(irrQ), .isrQ(isrQ), .imrQ(imrQ), .trigQ(trigQ),
    .st(st), .mode(mode), .initDone(initDone), .rdData(rdData)
  );

  irqc_datapath u_dp (
    .clk(clk), .rstN(rstN), .st(st), .mode(mode), .reqIn(irqReq),
    .irrQ(irrQ), .isrQ(isrQ), .imrQ(imrQ), .trigQ(trigQ), .baseQ(baseQ),
    .pendValid(pendValid), .pendLvl(pendLvl)
  );

  assign intOut = initDone && pendValid;
  assign intVec = baseQ | DATA_W'(pendLvl);
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
  import irqc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              addr,
  input logic [DATA_W-1:0] wrData,
  input logic [LINES-1:0]  irqReq,
  input logic              intOut,
  input logic              initDone,
  input logic [LVL_W-1:0]  pendLvl,
  input lineVec_t          irrQ,
  input lineVec_t          imrQ,
  input lineVec_t          trigQ
);
  AST_ICW1_DROPS_INT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && wrData[4]) |=> !intOut); // R1

  AST_INT_NEEDS_INIT: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> initDone); // R10

  AST_WINNER_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> !imrQ[pendLvl]); // R6

  AST_WINNER_REQUESTED: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> irrQ[pendLvl]); // R8

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irqReq[0]) && !trigQ[0]) |=> irrQ[0]); // R8
endmodule

bind prio_intc prio_intc_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .irqReq(irqReq), .intOut(intOut), .initDone(initDone), .pendLvl(pendLvl),
  .irrQ(irrQ), .imrQ(imrQ), .trigQ(trigQ)
);

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, addr = 1'b0, trigSel = 1'b0, intAck = 1'b0;
  logic [7:0] wrData = '0, irqReq = '0;
  logic [7:0] rdData, intVec;
  logic intOut;
  logic probeInt = 1'b0;
  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;

  typedef struct {
    bit         isRead;
    logic [8:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  prio_intc u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .trigSel(trigSel), .wrData(wrData), .rdData(rdData), .irqReq(irqReq),
    .intAck(intAck), .intOut(intOut), .intVec(intVec)
  );

  // Monitor: pops expected items and compares at the falling edge.
  always @(negedge clk) begin
    item_t it;
    logic [8:0] got;
    if (rdEn || probeInt) begin
      if (sb.size() == 0) begin
        nChecks++; nFail++;
        $display("FAIL scoreboard underflow: actual sample with no expected item, expected one queued");
      end else begin
        it = sb.pop_front();
        got = it.isRead ? {1'b0, rdData} : {intOut, intOut ? intVec : 8'h00};
        nChecks++;
        if (got !== it.exp) begin
          nFail++;
          $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic a, input logic ts, input logic [7:0] v);
    wrEn = 1'b1; addr = a; trigSel = ts; wrData = v;
    @(posedge clk); #1;
    wrEn = 1'b0; trigSel = 1'b0;
  endtask

  task automatic rd(input logic a, input logic ts, input logic [7:0] exp, input string tag);
    item_t it;
    it.isRead = 1'b1; it.exp = {1'b0, exp}; it.tag = tag;
    sb.push_back(it);
    rdEn = 1'b1; addr = a; trigSel = ts;
    @(posedge clk); #1;
    rdEn = 1'b0; trigSel = 1'b0;
  endtask

  task automatic chkInt(input logic o, input logic [7:0] v, input string tag);
    item_t it;
    it.isRead = 1'b0; it.exp = {o, o ? v : 8'h00}; it.tag = tag;
    sb.push_back(it);
    probeInt = 1'b1;
    @(posedge clk); #1;
    probeInt = 1'b0;
  endtask

  task automatic ack();
    intAck = 1'b1;
    @(posedge clk); #1;
    intAck = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    chkInt(1'b0, 8'h00, "R10 reset");
    rd(1'b1, 1'b0, 8'h00, "R2 mask reset");
    rd(1'b0, 1'b0, 8'h00, "R11 irr reset");
    // Request before init: latched but no interrupt
    irqReq = 8'h08; idle();
    chkInt(1'b0, 8'h00, "R10 pre-init");
    rd(1'b0, 1'b0, 8'h08, "R11 irr pre-init");
    // Initialization
    wr(1'b0, 1'b0, 8'h11);
    rd(1'b0, 1'b0, 8'h00, "R1 irr cleared");
    wr(1'b1, 1'b0, 8'h20);
    wr(1'b1, 1'b0, 8'h04);
    wr(1'b1, 1'b0, 8'h01);
    rd(1'b1, 1'b0, 8'h00, "R2 cascade ignored");
    // Edge on line 3
    irqReq = 8'h00; idle();
    irqReq = 8'h08; idle();
    chkInt(1'b1, 8'h23, "R10 vector");
    irqReq = 8'h28; idle();
    chkInt(1'b1, 8'h23, "R5 line3 over line5");
    ack();
    chkInt(1'b0, 8'h00, "R6 in-service blocks");
    wr(1'b0, 1'b0, 8'h0B);
    rd(1'b0, 1'b0, 8'h08, "R9 isr after ack");
    wr(1'b0, 1'b0, 8'h0A);
    rd(1'b0, 1'b0, 8'h20, "R11 irr select");
    wr(1'b0, 1'b0, 8'h20);
    chkInt(1'b1, 8'h25, "R3 nonspecific eoi");
    ack();
    wr(1'b0, 1'b0, 8'h65);
    wr(1'b0, 1'b0, 8'h0B);
    rd(1'b0, 1'b0, 8'h00, "R3 specific eoi");
    wr(1'b0, 1'b0, 8'h0A);
    // Priority pointer and rotation
    wr(1'b0, 1'b0, 8'hC4);
    irqReq = 8'h6C; idle();
    chkInt(1'b1, 8'h26, "R4 set priority");
    ack();
    chkInt(1'b0, 8'h00, "R6 blocked after ack");
    wr(1'b0, 1'b0, 8'hA0);
    chkInt(1'b1, 8'h22, "R4 rotate nonspecific");
    wr(1'b1, 1'b0, 8'h04);
    chkInt(1'b0, 8'h00, "R6 masked");
    rd(1'b1, 1'b0, 8'h04, "R2 mask readback");
    wr(1'b1, 1'b0, 8'h00);
    // Special mask mode
    ack();
    wr(1'b0, 1'b0, 8'hC7);
    irqReq = 8'h7C; idle();
    chkInt(1'b0, 8'h00, "R6 lower blocked");
    wr(1'b0, 1'b0, 8'h68);
    wr(1'b1, 1'b0, 8'h80);
    chkInt(1'b1, 8'h24, "R7 special mask");
    wr(1'b0, 1'b0, 8'h48);
    chkInt(1'b0, 8'h00, "R7 special mask off");
    wr(1'b1, 1'b0, 8'h00);
    wr(1'b0, 1'b0, 8'h62);
    // Poll
    wr(1'b0, 1'b0, 8'h0C);
    rd(1'b0, 1'b0, 8'h84, "R12 poll hit");
    rd(1'b0, 1'b0, 8'h00, "R12 poll disarmed");
    wr(1'b0, 1'b0, 8'h0B);
    rd(1'b0, 1'b0, 8'h10, "R12 poll into service");
    wr(1'b0, 1'b0, 8'h0A);
    wr(1'b0, 1'b0, 8'h64);
    wr(1'b0, 1'b0, 8'h0C);
    rd(1'b0, 1'b0, 8'h00, "R12 poll empty");
    // Level trigger on line 1
    wr(1'b1, 1'b1, 8'h02);
    rd(1'b1, 1'b1, 8'h02, "R8 trigger select");
    irqReq = 8'h7E; idle();
    chkInt(1'b1, 8'h21, "R8 level active");
    irqReq = 8'h7C; idle();
    chkInt(1'b0, 8'h00, "R8 level released");
    // Re-init with AEOI
    wr(1'b0, 1'b0, 8'h11);
    wr(1'b1, 1'b0, 8'h40);
    wr(1'b1, 1'b0, 8'h04);
    wr(1'b1, 1'b0, 8'h03);
    irqReq = 8'h7E; idle();
    chkInt(1'b1, 8'h41, "R9 aeoi level");
    ack();
    chkInt(1'b1, 8'h41, "R9 aeoi unblocked");
    wr(1'b0, 1'b0, 8'h0B);
    rd(1'b0, 1'b0, 8'h00, "R9 aeoi isr empty");
    wr(1'b0, 1'b0, 8'h0A);
    irqReq = 8'h00; idle();
    wr(1'b0, 1'b0, 8'h80);
    irqReq = 8'h09; idle();
    chkInt(1'b1, 8'h40, "R5 default order");
    ack();
    chkInt(1'b1, 8'h43, "R9 rotate on aeoi");
    // Same-cycle acknowledge and new edge on line 3
    irqReq = 8'h01; idle();
    irqReq = 8'h09; intAck = 1'b1;
    @(posedge clk); #1;
    intAck = 1'b0;
    rd(1'b0, 1'b0, 8'h08, "R13 edge during ack");
    idle();
    if (sb.size() != 0) begin
      nChecks++; nFail++;
      $display("FAIL scoreboard: actual %0d items left expected 0", sb.size());
    end
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule